// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's host data port, its serial receiver, its receive FIFO and its transmit path. A 2-bit channel-mode input selects one of four routings. Normal sends host bytes out and received bytes into the FIFO. Echo sends each received byte both into the FIFO and back out. Local loopback turns host bytes straight into the FIFO. Remote loopback sends received bytes back out and keeps them from the host. The block also holds the UART control register and decodes it. It produces the direction-active levels, the break level, and one-cycle pulses for the FIFO resets and the receive-timeout restart.

All byte traffic uses valid/ready streams. A byte moves on an edge where its valid and ready are both high. A source must hold valid and data stable until the byte is taken. Bytes that the current mode drops, or that target an inactive direction, are accepted at once (ready high) and produce nothing. A byte bound for two sinks (echo) is taken only when both sinks can take it. Each output stream has a one-stage register. It sustains one byte per cycle, and its ready path back to the source is combinational.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control value reads 0x128. Receive, transmit and break are inactive, and neither output stream is valid.
- R2: Control bit positions are: 0 receive reset, 1 transmit reset, 2 receive enable, 3 receive disable, 4 transmit enable, 5 transmit disable, 6 timeout restart, 7 break start, 8 break stop. A direction is active only when its enable bit is 1 and its disable bit is 0. Break is active only when break start is 1 and break stop is 0.
- R3: Written 1 to bit 0 or bit 1, the bit reads back as 0. On the cycle after the write, the matching flush output (rx_flush for bit 0, tx_flush for bit 1) is high for exactly one cycle.
- R4: Mode 0 (normal) routes received bytes to the FIFO stream and host bytes to the transmit stream.
- R5: Mode 1 (echo) routes each received byte to both the FIFO and transmit streams with the same data in the same cycle. It is accepted only when both can take it, so a stalled FIFO side blocks the receiver and no duplicate reaches the transmit side.
- R6: Mode 2 (local loopback) routes host bytes to the FIFO stream. Received bytes are accepted and dropped.
- R7: Mode 3 (remote loopback) routes received bytes to the transmit stream. Host bytes are accepted and dropped.
- R8: A byte whose destination direction is inactive is accepted and discarded, and no push appears on that stream.
- R9: An output byte appears the cycle after its acceptance. It holds valid and data stable while its ready is low.
- R10: A flush pulse empties the corresponding output register, so a held byte is discarded.
- R11: A control write with bit 6 set gives a one-cycle tmo_kick pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loop, 3 remote loop |
| host_valid | input | 1 | Host data byte valid |
| host_data | input | 8 | Host data byte |
| host_ready | output | 1 | Host byte accepted |
| rxd_valid | input | 1 | Received byte valid |
| rxd_data | input | 8 | Received byte |
| rxd_ready | output | 1 | Received byte accepted |
| fifo_valid | output | 1 | Push to receive FIFO valid |
| fifo_data | output | 8 | Byte for receive FIFO |
| fifo_ready | input | 1 | Receive FIFO can take a byte |
| tx_valid | output | 1 | Push to transmit path valid |
| tx_data | output | 8 | Byte for transmit path |
| tx_ready | input | 1 | Transmit path can take a byte |
| ctrl_q | output | 9 | Current control value |
| rx_on | output | 1 | Receive direction active |
| tx_on | output | 1 | Transmit direction active |
| brk_on | output | 1 | Break active |
| rx_flush | output | 1 | One-cycle receive reset pulse |
| tx_flush | output | 1 | One-cycle transmit reset pulse |
| tmo_kick | output | 1 | One-cycle timeout restart pulse |

## Verification
The hardest case to reach is the echo fork. One branch must be stalled while the other keeps draining, so that a late acceptance would show up as a duplicate on the transmit side. The stimulus first loads both output registers with one echoed byte while fifo_ready is low. It lets the transmit side drain, then holds a second received byte at the input. The bench checks that this byte is refused and that the transmit stream stays empty until the FIFO side frees. Flushing a held byte needs the same kind of setup: a byte is parked behind a low ready, and then a reset bit is written.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  localparam int CTRL_BITS = 9;

  localparam int B_RXRST = 0;
  localparam int B_TXRST = 1;
  localparam int B_RXEN  = 2;
  localparam int B_RXDIS = 3;
  localparam int B_TXEN  = 4;
  localparam int B_TXDIS = 5;
  localparam int B_TMO   = 6;
  localparam int B_BRKGO = 7;
  localparam int B_BRKNO = 8;

  localparam logic [CTRL_BITS-1:0] CTRL_RST_VAL = 9'h128;
  localparam logic [CTRL_BITS-1:0] SELF_CLR_MASK =
    (9'd1 << B_RXRST) | (9'd1 << B_TXRST);

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LLOOP  = 2'd2,
    CM_RLOOP  = 2'd3
  } chan_mode_e;

  typedef struct packed {
    logic rx_fifo;
    logic rx_tx;
    logic host_tx;
    logic host_fifo;
  } route_t;

  function automatic route_t route_of(chan_mode_e m, logic rx_act, logic tx_act);
    route_t r;
    r.rx_fifo   = (m == CM_NORMAL || m == CM_ECHO) && rx_act;
    r.rx_tx     = (m == CM_ECHO || m == CM_RLOOP) && tx_act;
    r.host_tx   = (m == CM_NORMAL) && tx_act;
    r.host_fifo = (m == CM_LLOOP) && rx_act;
    return r;
  endfunction
endpackage

// File: rtl/urt_ctrl_dec.sv
module urt_ctrl_dec
  import uart_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wdata,
  output logic [CTRL_BITS-1:0] ctrl_q,
  output logic                 rx_on,
  output logic                 tx_on,
  output logic                 brk_on,
  output logic                 rx_flush,
  output logic                 tx_flush,
  output logic                 tmo_kick
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST_VAL;
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
      tmo_kick <= 1'b0;
    end else begin
      rx_flush <= wr_en && wdata[B_RXRST];
      tx_flush <= wr_en && wdata[B_TXRST];
      tmo_kick <= wr_en && wdata[B_TMO];
      if (wr_en) ctrl_q <= wdata & ~SELF_CLR_MASK;
    end
  end

  assign rx_on  = ctrl_q[B_RXEN]  && !ctrl_q[B_RXDIS];
  assign tx_on  = ctrl_q[B_TXEN]  && !ctrl_q[B_TXDIS];
  assign brk_on = ctrl_q[B_BRKGO] && !ctrl_q[B_BRKNO];

  // R3
  rx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> $past(wr_en && wdata[B_RXRST]));
  // R3
  tx_flush_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush && !(wr_en && wdata[B_TXRST]) |=> !tx_flush);
  // R2
  rx_dis_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[B_RXDIS] |=> !rx_on);
  // R2
  tx_dis_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[B_TXDIS] |=> !tx_on);
endmodule

// File: rtl/urt_route_core.sv
module urt_route_core
  import uart_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_mode_e        mode,
  input  logic              rx_on,
  input  logic              tx_on,
  input  logic              rxd_valid,
  input  logic [DATA_W-1:0] rxd_data,
  output logic              rxd_ready,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_ready,
  output logic              f_valid,
  output logic [DATA_W-1:0] f_data,
  input  logic              f_ready,
  output logic              t_valid,
  output logic [DATA_W-1:0] t_data,
  input  logic              t_ready
);
  route_t rt;

  always_comb begin
    rt         = route_of(mode, rx_on, tx_on);
    rxd_ready  = (!rt.rx_fifo || f_ready) && (!rt.rx_tx || t_ready);
    host_ready = (!rt.host_fifo || f_ready) && (!rt.host_tx || t_ready);
    f_valid    = (rt.rx_fifo && rxd_valid && (!rt.rx_tx || t_ready))
              || (rt.host_fifo && host_valid);
    t_valid    = (rt.rx_tx && rxd_valid && (!rt.rx_fifo || f_ready))
              || (rt.host_tx && host_valid);
    f_data     = rt.host_fifo ? host_data : rxd_data;
    t_data     = rt.host_tx ? host_data : rxd_data;
  end

  // R8
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> tx_on);
  // R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> rx_on);
  // R5
  echo_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_ECHO && rx_on && tx_on && rxd_valid && rxd_ready)
      |-> (f_valid && t_valid && f_data == t_data));
  // R6
  lloop_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == CM_LLOOP |-> !t_valid);
  // R7
  rloop_no_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == CM_RLOOP |-> !f_valid);
endmodule

// File: rtl/urt_out_stage.sv
module urt_out_stage #(
  parameter int DATA_W = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              i_valid,
  input  logic [DATA_W-1:0] i_data,
  output logic              i_ready,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_data,
  input  logic              o_ready
);
  generate
    if (OUT_REG) begin : g_reg
      logic              full_q;
      logic [DATA_W-1:0] data_q;

      assign i_ready = !full_q || o_ready;
      assign o_valid = full_q;
      assign o_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (flush) begin
          full_q <= 1'b0;
        end else if (i_ready) begin
          full_q <= i_valid;
          if (i_valid) data_q <= i_data;
        end
      end

      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready && !flush |=> o_valid && $stable(o_data));
      // R10
      flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !o_valid);
    end else begin : g_pass
      assign o_valid = i_valid && !flush;
      assign o_data  = i_data;
      assign i_ready = o_ready || flush;
    end
  endgenerate
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_route_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic [CTRL_BITS-1:0] ctrl_wdata,
  input  logic [1:0]           chan_mode,
  input  logic                 host_valid,
  input  logic [DATA_W-1:0]    host_data,
  output logic                 host_ready,
  input  logic                 rxd_valid,
  input  logic [DATA_W-1:0]    rxd_data,
  output logic                 rxd_ready,
  output logic                 fifo_valid,
  output logic [DATA_W-1:0]    fifo_data,
  input  logic                 fifo_ready,
  output logic                 tx_valid,
  output logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_ready,
  output logic [CTRL_BITS-1:0] ctrl_q,
  output logic                 rx_on,
  output logic                 tx_on,
  output logic                 brk_on,
  output logic                 rx_flush,
  output logic                 tx_flush,
  output logic                 tmo_kick
);
  logic              f_valid, f_ready, t_valid, t_ready;
  logic [DATA_W-1:0] f_data, t_data;

  urt_ctrl_dec u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (ctrl_wdata),
    .ctrl_q   (ctrl_q),
    .rx_on    (rx_on),
    .tx_on    (tx_on),
    .brk_on   (brk_on),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .tmo_kick (tmo_kick)
  );

  urt_route_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (chan_mode_e'(chan_mode)),
    .rx_on      (rx_on),
    .tx_on      (tx_on),
    .rxd_valid  (rxd_valid),
    .rxd_data   (rxd_data),
    .rxd_ready  (rxd_ready),
    .host_valid (host_valid),
    .host_data  (host_data),
    .host_ready (host_ready),
    .f_valid    (f_valid),
    .f_data     (f_data),
    .f_ready    (f_ready),
    .t_valid    (t_valid),
    .t_data     (t_data),
    .t_ready    (t_ready)
  );

  urt_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_fifo_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (rx_flush),
    .i_valid (f_valid),
    .i_data  (f_data),
    .i_ready (f_ready),
    .o_valid (fifo_valid),
    .o_data  (fifo_data),
    .o_ready (fifo_ready)
  );

  urt_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_tx_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (tx_flush),
    .i_valid (t_valid),
    .i_data  (t_data),
    .i_ready (t_ready),
    .o_valid (tx_valid),
    .o_data  (tx_data),
    .o_ready (tx_ready)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !fifo_valid && !tx_valid && ctrl_q == CTRL_RST_VAL);
endmodule

// File: tb/sim_uart_chan_router.sv
module sim_uart_chan_router;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [8:0] ctrl_wdata = '0;
  logic [1:0] chan_mode = 2'd0;
  logic       host_valid = 1'b0;
  logic [7:0] host_data = '0;
  logic       host_ready;
  logic       rxd_valid = 1'b0;
  logic [7:0] rxd_data = '0;
  logic       rxd_ready;
  logic       fifo_valid;
  logic [7:0] fifo_data;
  logic       fifo_ready = 1'b1;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b1;
  logic [8:0] ctrl_q;
  logic       rx_on, tx_on, brk_on, rx_flush, tx_flush, tmo_kick;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  uart_chan_router u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .chan_mode(chan_mode), .host_valid(host_valid), .host_data(host_data),
    .host_ready(host_ready), .rxd_valid(rxd_valid), .rxd_data(rxd_data),
    .rxd_ready(rxd_ready), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ctrl_q(ctrl_q), .rx_on(rx_on), .tx_on(tx_on),
    .brk_on(brk_on), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .tmo_kick(tmo_kick)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [8:0] v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(posedge clk);
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_wdata = '0;
    #1;
  endtask

  // drive one received byte for one accepted edge; returns at negedge after it
  task automatic send_rx(logic [7:0] d, int exp_ready, string tag);
    @(negedge clk);
    rxd_valid = 1'b1; rxd_data = d;
    #1;
    chk(tag, rxd_ready, exp_ready);
    @(posedge clk);
    @(negedge clk);
    rxd_valid = 1'b0;
    #1;
  endtask

  task automatic send_host(logic [7:0] d, int exp_ready, string tag);
    @(negedge clk);
    host_valid = 1'b1; host_data = d;
    #1;
    chk(tag, host_ready, exp_ready);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 ctrl_q", ctrl_q, 9'h128);
    chk("R1 rx_on", rx_on, 0);
    chk("R1 tx_on", tx_on, 0);
    chk("R1 brk_on", brk_on, 0);
    chk("R1 fifo_valid", fifo_valid, 0);
    chk("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_disabled_drop();
    chan_mode = 2'd0;
    send_rx(8'h12, 1, "R8 rx ready when rx off");
    chk("R8 no fifo push when rx off", fifo_valid, 0);
    send_host(8'h34, 1, "R8 host ready when tx off");
    chk("R8 no tx push when tx off", tx_valid, 0);
  endtask

  task automatic t_enable_prio();
    wr_ctrl(9'h03C);
    chk("R2 rx disable wins", rx_on, 0);
    chk("R2 tx disable wins", tx_on, 0);
    wr_ctrl(9'h094);
    chk("R2 rx on", rx_on, 1);
    chk("R2 tx on", tx_on, 1);
    chk("R2 break on", brk_on, 1);
    wr_ctrl(9'h194);
    chk("R2 break stop wins", brk_on, 0);
    wr_ctrl(9'h014);
  endtask

  task automatic t_normal();
    chan_mode = 2'd0;
    send_rx(8'hA5, 1, "R4 rx ready");
    chk("R4 fifo valid", fifo_valid, 1);
    chk("R9 fifo data", fifo_data, 8'hA5);
    chk("R4 no tx from rx", tx_valid, 0);
    idle(1);
    send_host(8'h3C, 1, "R4 host ready");
    chk("R4 tx valid", tx_valid, 1);
    chk("R4 tx data", tx_data, 8'h3C);
    chk("R4 no fifo from host", fifo_valid, 0);
    idle(1);
  endtask

  task automatic t_echo();
    chan_mode = 2'd1;
    send_rx(8'h5A, 1, "R5 rx ready");
    chk("R5 fifo copy", fifo_data, 8'h5A);
    chk("R5 tx copy", tx_data, 8'h5A);
    chk("R5 both valid", fifo_valid & tx_valid, 1);
    idle(1);
    // stall fifo side: load both, then hold next byte
    @(negedge clk);
    fifo_ready = 1'b0;
    rxd_valid = 1'b1; rxd_data = 8'h11;
    @(posedge clk);
    @(negedge clk);
    rxd_data = 8'h22;
    #1;
    chk("R5 blocked while fifo full", rxd_ready, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R5 no duplicate on tx", tx_valid, 0);
    chk("R9 fifo held", fifo_data, 8'h11);
    chk("R9 fifo still valid", fifo_valid, 1);
    fifo_ready = 1'b1;
    #1;
    chk("R5 accepted once free", rxd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    rxd_valid = 1'b0;
    #1;
    chk("R5 fifo next", fifo_data, 8'h22);
    chk("R5 tx next", tx_data, 8'h22);
    idle(1);
  endtask

  task automatic t_lloop();
    chan_mode = 2'd2;
    send_host(8'h77, 1, "R6 host ready");
    chk("R6 fifo from host", fifo_data, 8'h77);
    chk("R6 fifo valid", fifo_valid, 1);
    chk("R6 no tx", tx_valid, 0);
    idle(1);
    send_rx(8'h66, 1, "R6 rx dropped ready");
    chk("R6 rx not pushed", fifo_valid | tx_valid, 0);
  endtask

  task automatic t_rloop();
    chan_mode = 2'd3;
    send_rx(8'h99, 1, "R7 rx ready");
    chk("R7 tx data", tx_data, 8'h99);
    chk("R7 tx valid", tx_valid, 1);
    chk("R7 no fifo", fifo_valid, 0);
    idle(1);
    send_host(8'h44, 1, "R7 host dropped ready");
    chk("R7 host not pushed", fifo_valid | tx_valid, 0);
  endtask

  task automatic t_tx_gate();
    chan_mode = 2'd1;
    wr_ctrl(9'h024);
    send_rx(8'hE1, 1, "R8 echo rx ready");
    chk("R8 echo fifo still pushed", fifo_valid, 1);
    chk("R8 echo tx gated", tx_valid, 0);
    idle(1);
    wr_ctrl(9'h014);
  endtask

  task automatic t_flush();
    chan_mode = 2'd0;
    fifo_ready = 1'b0;
    send_rx(8'hC3, 1, "R10 rx load");
    chk("R10 held before flush", fifo_valid, 1);
    wr_ctrl(9'h015);
    chk("R3 rx_flush pulse", rx_flush, 1);
    chk("R3 rx reset bit self clears", ctrl_q, 9'h014);
    idle(1);
    chk("R3 rx_flush one cycle", rx_flush, 0);
    chk("R10 fifo emptied", fifo_valid, 0);
    fifo_ready = 1'b1;
    tx_ready = 1'b0;
    send_host(8'hB4, 1, "R10 host load");
    chk("R10 tx held", tx_valid, 1);
    wr_ctrl(9'h016);
    chk("R3 tx_flush pulse", tx_flush, 1);
    chk("R3 tx reset bit self clears", ctrl_q, 9'h014);
    idle(1);
    chk("R10 tx emptied", tx_valid, 0);
    tx_ready = 1'b1;
  endtask

  task automatic t_kick();
    wr_ctrl(9'h054);
    chk("R11 kick pulse", tmo_kick, 1);
    idle(1);
    chk("R11 kick one cycle", tmo_kick, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_disabled_drop();
    t_enable_prio();
    t_normal();
    t_echo();
    t_lloop();
    t_rloop();
    t_tx_gate();
    t_flush();
    t_kick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule